// File: doc/BRIEF.md
# Text and Low-Resolution Pixel Decoder

This block sits between the display fetch logic and the pixel pipeline of a character-cell video generator. Each fetched display byte arrives with the scan line inside its eight-line character cell and a mode select. The block turns it into what should be drawn. In low-resolution graphics mode a byte holds two stacked colour blocks. The upper half of the cell takes the low nibble and the lower half takes the high nibble, so the block emits one 4-bit colour index.

In text mode the same byte carries a 6-bit character code in its low bits. Its two top bits pick the display style: normal, inverse (dark on light) or flashing. For flashing characters the block keeps a frame counter that flips a blink phase at a fixed frame interval. A flashing character is drawn inverted only while that phase is set. All outputs are registered and appear one clock after the byte is presented. The glyph lookup and the analogue colour synthesis sit downstream of this block.

Top module: `cell_byte_decoder`

## Requirements
- R1: out_valid is high in the cycle after a cycle with in_valid high, and low in the cycle after a cycle with in_valid low.
- R2: In graphics mode (mode_gfx=1), a scan line of 0 to 3 (in_line[2]=0) makes out_color equal in_byte[3:0].
- R3: In graphics mode, a scan line of 4 to 7 (in_line[2]=1) makes out_color equal in_byte[7:4]. For example, 0xC1 gives 1 on the upper lines and 12 on the lower lines.
- R4: In graphics mode, out_char and out_invert are both 0.
- R5: In text mode (mode_gfx=0), out_char equals in_byte[5:0] and out_color is 0. For example, 0xC1 gives 0x01.
- R6: In text mode, a byte with bit 7 set (style normal) gives out_invert=0.
- R7: In text mode, a byte with bits 7:6 = 00 (style inverse) gives out_invert=1.
- R8: In text mode, a byte with bits 7:6 = 01 (style flashing) gives out_invert equal to the blink phase. The blink phase is 0 after reset.
- R9: The blink phase toggles on every 16th frame_stb pulse counted from reset. A pulse in the same cycle as a byte takes effect from the next byte onward.
- R10: While rst is high, and in the cycle after it, out_valid, out_color, out_char and out_invert are all 0.
- R11: After a cycle with in_valid low, out_color, out_char and out_invert keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A display byte is presented this cycle |
| in_byte | input | 8 | Fetched display byte |
| in_line | input | 3 | Scan line within the character cell |
| mode_gfx | input | 1 | 1 selects low-resolution graphics, 0 selects text |
| frame_stb | input | 1 | One-cycle pulse once per frame |
| out_valid | output | 1 | Registered outputs hold a new result |
| out_color | output | 4 | Colour index (graphics mode) |
| out_char | output | 6 | Character code (text mode) |
| out_invert | output | 1 | Draw the character inverted |

## Verification
The properties assume that rst is released synchronously and that every input is a defined value at each rising edge. They relate each output only to the inputs of the previous cycle, so no alignment between frame_stb and the byte stream is required. The stimulus changes inputs only on the falling edge. It mixes random bytes, lines, modes and strobes with directed runs that walk the blink counter across its wrap point, including a strobe in the same cycle as a flashing byte.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  typedef enum logic [1:0] {
    STY_INVERSE = 2'b00,
    STY_FLASH   = 2'b01,
    STY_NORM_A  = 2'b10,
    STY_NORM_B  = 2'b11
  } style_e;
endpackage

// File: rtl/cbd_blink_timer.sv
module cbd_blink_timer #(
  parameter int FLASH_FRAMES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_stb,
  output logic phase
);
  localparam int CNT_W = (FLASH_FRAMES > 1) ? $clog2(FLASH_FRAMES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FLASH_FRAMES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (frame_stb) begin
      if (cnt == LAST) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cbd_byte_split.sv
module cbd_byte_split #(
  parameter int BYTE_W = 8,
  parameter int LINE_W = 3
) (
  input  logic [BYTE_W-1:0]   byte_in,
  input  logic [LINE_W-1:0]   line_in,
  input  logic                gfx,
  input  logic                phase,
  output logic [BYTE_W/2-1:0] color,
  output logic [BYTE_W-3:0]   chr,
  output logic                inv
);
  import cbd_pkg::*;
  localparam int NIB_W = BYTE_W / 2;

  style_e sty;
  assign sty = style_e'(byte_in[BYTE_W-1 -: 2]);

  always_comb begin
    color = '0;
    chr   = '0;
    inv   = 1'b0;
    if (gfx) begin
      color = line_in[LINE_W-1] ? byte_in[BYTE_W-1 -: NIB_W] : byte_in[NIB_W-1:0];
    end else begin
      chr = byte_in[BYTE_W-3:0];
      unique case (sty)
        STY_INVERSE: inv = 1'b1;
        STY_FLASH:   inv = phase;
        default:     inv = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cell_byte_decoder.sv
module cell_byte_decoder #(
  parameter int BYTE_W       = 8,
  parameter int LINE_W       = 3,
  parameter int FLASH_FRAMES = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [BYTE_W-1:0]   in_byte,
  input  logic [LINE_W-1:0]   in_line,
  input  logic                mode_gfx,
  input  logic                frame_stb,
  output logic                out_valid,
  output logic [BYTE_W/2-1:0] out_color,
  output logic [BYTE_W-3:0]   out_char,
  output logic                out_invert
);
  localparam int NIB_W  = BYTE_W / 2;
  localparam int CHAR_W = BYTE_W - 2;

  logic              phase;
  logic [NIB_W-1:0]  nx_color;
  logic [CHAR_W-1:0] nx_char;
  logic              nx_inv;

  cbd_blink_timer #(.FLASH_FRAMES(FLASH_FRAMES)) u_blink (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .phase(phase)
  );

  cbd_byte_split #(.BYTE_W(BYTE_W), .LINE_W(LINE_W)) u_split (
    .byte_in(in_byte), .line_in(in_line), .gfx(mode_gfx), .phase(phase),
    .color(nx_color), .chr(nx_char), .inv(nx_inv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_color  <= '0;
      out_char   <= '0;
      out_invert <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_color  <= nx_color;
        out_char   <= nx_char;
        out_invert <= nx_inv;
      end
    end
  end
endmodule

// File: rtl/cbd_checker.sv
module cbd_checker #(
  parameter int BYTE_W = 8,
  parameter int LINE_W = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [BYTE_W-1:0]   in_byte,
  input logic [LINE_W-1:0]   in_line,
  input logic                mode_gfx,
  input logic                out_valid,
  input logic [BYTE_W/2-1:0] out_color,
  input logic [BYTE_W-3:0]   out_char,
  input logic                out_invert
);
  localparam int NIB_W = BYTE_W / 2;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);  // R1
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);  // R1
  AST_UPPER_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_gfx && !in_line[LINE_W-1]) |=> out_color == $past(in_byte[NIB_W-1:0]));  // R2
  AST_LOWER_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_gfx && in_line[LINE_W-1]) |=> out_color == $past(in_byte[BYTE_W-1 -: NIB_W]));  // R3
  AST_GFX_NO_TEXT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_gfx) |=> (out_char == '0 && !out_invert));  // R4
  AST_TEXT_CODE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode_gfx) |=> (out_char == $past(in_byte[BYTE_W-3:0]) && out_color == '0));  // R5
  AST_NORMAL_PLAIN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode_gfx && in_byte[BYTE_W-1]) |=> !out_invert);  // R6
  AST_INVERSE_SET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode_gfx && in_byte[BYTE_W-1 -: 2] == 2'b00) |=> out_invert);  // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_color) && $stable(out_char) && $stable(out_invert)));  // R11
endmodule

bind cell_byte_decoder cbd_checker #(.BYTE_W(BYTE_W), .LINE_W(LINE_W)) u_cbd_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_line(in_line),
  .mode_gfx(mode_gfx), .out_valid(out_valid), .out_color(out_color),
  .out_char(out_char), .out_invert(out_invert)
);

// File: tb/cell_byte_decoder_bench.sv
`timescale 1ns/1ps
module cell_byte_decoder_bench;
  localparam int FLASH_FRAMES = 16;

  logic clk = 1'b0;
  logic rst, in_valid, mode_gfx, frame_stb;
  logic [7:0] in_byte;
  logic [2:0] in_line;
  logic out_valid, out_invert;
  logic [3:0] out_color;
  logic [5:0] out_char;

  int checks = 0;
  int errors = 0;

  int   m_cnt;
  logic m_phase;
  logic [3:0] e_color;
  logic [5:0] e_char;
  logic e_inv;

  always #4 clk = ~clk;

  cell_byte_decoder #(.FLASH_FRAMES(FLASH_FRAMES)) u_cell_byte_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_line(in_line),
    .mode_gfx(mode_gfx), .frame_stb(frame_stb), .out_valid(out_valid),
    .out_color(out_color), .out_char(out_char), .out_invert(out_invert)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic f_inv(input logic [7:0] b, input logic g, input logic ph);
    if (g) return 1'b0;
    if (b[7]) return 1'b0;
    if (!b[6]) return 1'b1;
    return ph;
  endfunction

  task automatic step(input logic v, input logic [7:0] b, input logic [2:0] l,
                      input logic g, input logic f, input string tag);
    @(negedge clk);
    in_valid = v; in_byte = b; in_line = l; mode_gfx = g; frame_stb = f;
    if (v) begin
      e_color = g ? (l[2] ? b[7:4] : b[3:0]) : 4'd0;
      e_char  = g ? 6'd0 : b[5:0];
      e_inv   = f_inv(b, g, m_phase);
    end
    @(posedge clk);
    #1;
    chk({tag, " R1 valid"}, out_valid, v);
    chk({tag, " colour"}, out_color, e_color);
    chk({tag, " char"}, out_char, e_char);
    chk({tag, " invert"}, out_invert, e_inv);
    if (f) begin
      if (m_cnt == FLASH_FRAMES - 1) begin m_cnt = 0; m_phase = ~m_phase; end
      else m_cnt++;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 0; in_byte = 0; in_line = 0; mode_gfx = 0; frame_stb = 0;
    m_cnt = 0; m_phase = 0; e_color = 0; e_char = 0; e_inv = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset valid", out_valid, 0);
    chk("R10 reset colour", out_color, 0);
    chk("R10 reset char", out_char, 0);
    chk("R10 reset invert", out_invert, 0);
    @(negedge clk); rst = 1'b0;

    step(1, 8'hC1, 3'd0, 1, 0, "R2 C1 upper");
    step(1, 8'hC1, 3'd3, 1, 0, "R2 C1 line3");
    step(1, 8'hC1, 3'd4, 1, 0, "R3 C1 line4");
    step(1, 8'hC1, 3'd7, 1, 0, "R3 R4 C1 lower");
    step(1, 8'hC1, 3'd2, 0, 0, "R5 R6 C1 text");
    step(0, 8'h00, 3'd0, 1, 0, "R11 hold");
    step(1, 8'h3F, 3'd0, 0, 0, "R7 inverse");
    step(0, 8'hFF, 3'd5, 0, 0, "R11 hold inverse");
    step(1, 8'h41, 3'd1, 0, 0, "R8 flash phase0");
    step(1, 8'h80, 3'd6, 0, 0, "R6 normal 80");

    for (int i = 0; i < FLASH_FRAMES - 1; i++) step(0, 8'h00, 3'd0, 0, 1, "R9 count");
    step(1, 8'h55, 3'd0, 0, 0, "R9 before wrap");
    step(1, 8'h55, 3'd0, 0, 1, "R9 strobe same cycle");
    step(1, 8'h55, 3'd0, 0, 0, "R9 R8 after wrap");
    for (int i = 0; i < FLASH_FRAMES; i++) step(0, 8'h00, 3'd0, 0, 1, "R9 count back");
    step(1, 8'h40, 3'd0, 0, 0, "R9 second toggle");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[15:8], r[18:16], r[2], (r[7:4] == 4'd0), "R1 R2 R3 R5 R8 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule